// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This unit judges one USB transfer descriptor once the bus side has finished a transaction on it. It takes the descriptor's 32-bit control word, its 32-bit token word and a result code with a byte count from the bus engine. From these it works out four things: the control word that should go back to memory, a verdict for the list walker (advance the queue, hold, or abort the frame), interrupt cause flags, and the controller error flags. It also splits the token into packet identifier, device address, endpoint and maximum length, so the walker does not need its own decoder.

All outputs are registered. A request presented with `in_valid` high is answered one clock later with `out_valid` high. The result holds until the next request. A `ctrl_changed` flag tells the caller whether the new control word differs from the one read, so the write-back can be skipped when nothing changed. Fetching descriptors and moving packet data are left to the surrounding logic.

Control word bits used: 29 short-packet detect, 28:27 error countdown, 25 isochronous, 24 interrupt on complete, 23 active, 22 stalled, 20 babble, 19 NAK, 18 timeout, 10:0 actual length minus one. Token bits used: 7:0 packet identifier, 14:8 device address, 18:15 endpoint, 31:21 maximum length minus one.

Top module: `td_status_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` is low and every data output is zero.
- R2: A request sampled with `in_valid` high shows up on the outputs at the next clock edge with `out_valid` high. Without a request, `out_valid` is low after the edge. The decoded fields are: `pid` = token bits 7:0, `dev_addr` = bits 14:8, `endpoint` = bits 18:15, and `max_len` = (bits 31:21 + 1) modulo 2048.
- R3: Cause bit 0 (completion) equals control bit 24 for every request. This holds for inactive descriptors and for invalid packet identifiers too.
- R4: When control bit 23 (active) is clear, the control word comes back unchanged, the verdict is hold (2'b01), and no error flag is raised.
- R5: An active descriptor whose packet identifier is not OUT (8'hE1), IN (8'h69) or SETUP (8'h2D) leaves the control word unchanged. It raises `proc_err` and gives verdict abort (2'b10).
- R6: On success (result code 0), bits 10:0 become (length − 1) mod 2048 and bit 23 is cleared. The length is `max_len` for OUT and SETUP, and `res_len` for IN. Unless R7 applies, the verdict is advance (2'b00).
- R7: A successful IN whose length is below `max_len`, with bit 29 set, raises cause bit 1 (short packet) and gives verdict hold.
- R8: Babble (result code 4, or an IN success with `res_len` > `max_len`) sets bits 20 and 22 and clears bit 23. It leaves bits 10:0 as they were and gives verdict abort.
- R9: No device (result code 1, and codes 5 to 7) sets bit 18 and takes the timeout path. A non-zero count in bits 28:27 is decremented; a count of zero stays zero. A decrement that reaches zero clears bit 23 and raises `usb_err`. The verdict is hold.
- R10: NAK (result code 2) sets bit 19 and gives verdict hold. For SETUP it also takes the timeout path of R9.
- R11: Stall (result code 3) sets bit 22, clears bit 23 and gives verdict hold.
- R12: For an active descriptor with a valid packet identifier, bit 25 set clears bit 23 whatever the result.
- R13: `ctrl_changed` is high exactly when `ctrl_out` differs from the control word of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| ctrl_in | input | 32 | Descriptor control word as read |
| token_in | input | 32 | Descriptor token word |
| res_kind | input | 3 | Bus result: 0 ok, 1 no device, 2 NAK, 3 stall, 4 babble, 5-7 as no device |
| res_len | input | RLEN_W | Byte count returned by the bus for IN |
| out_valid | output | 1 | Result strobe |
| ctrl_out | output | 32 | Updated control word |
| verdict | output | 2 | 00 advance, 01 hold, 10 abort frame |
| cause | output | 2 | Bit 0 completion, bit 1 short packet |
| usb_err | output | 1 | Error countdown expired |
| proc_err | output | 1 | Invalid packet identifier |
| ctrl_changed | output | 1 | Control word differs from input |
| pid | output | 8 | Decoded packet identifier |
| dev_addr | output | 7 | Decoded device address |
| endpoint | output | 4 | Decoded endpoint |
| max_len | output | LEN_W | Decoded maximum length |

## Verification
The bench builds the unit with the default LEN_W = 11 and RLEN_W = 12. The 12-bit byte count can report more bytes than even the largest maximum length of 2047, so clipped IN transfers are reachable for every token. The all-ones length field wraps to a maximum of zero; there an empty IN counts as a full packet and any data at all counts as babble. Random control and token words meet every result code and error count, and directed vectors cover each boundary.

// File: rtl/td_pkg.sv
package td_pkg;
  localparam int WORD_W = 32;

  // control word bit positions (decoded by the list walker)
  localparam int B_SPD    = 29;
  localparam int B_ERR_LO = 27;
  localparam int B_ISO    = 25;
  localparam int B_IOC    = 24;
  localparam int B_ACT    = 23;
  localparam int B_STALL  = 22;
  localparam int B_BABBLE = 20;
  localparam int B_NAK    = 19;
  localparam int B_TMO    = 18;

  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_SETUP = 8'h2D;

  localparam logic [2:0] RS_OK     = 3'd0;
  localparam logic [2:0] RS_NODEV  = 3'd1;
  localparam logic [2:0] RS_NAK    = 3'd2;
  localparam logic [2:0] RS_STALL  = 3'd3;
  localparam logic [2:0] RS_BABBLE = 3'd4;

  typedef enum logic [1:0] {
    VD_ADV   = 2'b00,
    VD_HOLD  = 2'b01,
    VD_ABORT = 2'b10
  } verdict_e;
endpackage

// File: rtl/td_tok_decode.sv
module td_tok_decode
  import td_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic [WORD_W-1:0] token,
  output logic [7:0]        pid,
  output logic [6:0]        dev_addr,
  output logic [3:0]        endpoint,
  output logic [LEN_W-1:0]  max_len
);
  localparam int MAXF_LSB = WORD_W - LEN_W;

  assign pid      = token[7:0];
  assign dev_addr = token[14:8];
  assign endpoint = token[18:15];
  // field holds length minus one; all ones wraps to zero
  assign max_len  = token[WORD_W-1:MAXF_LSB] + LEN_W'(1);
endmodule

// File: rtl/td_eval.sv
module td_eval
  import td_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int RLEN_W = 12
) (
  input  logic [WORD_W-1:0] ctrl,
  input  logic [7:0]        pid,
  input  logic [LEN_W-1:0]  max_len,
  input  logic [2:0]        res_kind,
  input  logic [RLEN_W-1:0] res_len,
  output logic [WORD_W-1:0] ctrl_new,
  output verdict_e          verdict,
  output logic [1:0]        cause,
  output logic              usb_err,
  output logic              proc_err
);
  logic             pid_ok, is_in, is_setup, tmo_path;
  logic [2:0]       kind;
  logic [LEN_W-1:0] eff_len;
  logic [1:0]       err_cnt;

  assign is_in    = (pid == PID_IN);
  assign is_setup = (pid == PID_SETUP);
  assign pid_ok   = is_in || is_setup || (pid == PID_OUT);
  assign err_cnt  = ctrl[B_ERR_LO+1:B_ERR_LO];

  always_comb begin
    ctrl_new = ctrl;
    verdict  = VD_HOLD;
    cause    = {1'b0, ctrl[B_IOC]};
    usb_err  = 1'b0;
    proc_err = 1'b0;
    tmo_path = 1'b0;
    kind     = res_kind;
    eff_len  = max_len;
    if (!ctrl[B_ACT]) begin
      // inactive: untouched
    end else if (!pid_ok) begin
      proc_err = 1'b1;
      verdict  = VD_ABORT;
    end else begin
      if (is_in && res_kind == RS_OK) begin
        if (res_len > RLEN_W'(max_len)) kind = RS_BABBLE;
        else eff_len = res_len[LEN_W-1:0];
      end
      if (ctrl[B_ISO]) ctrl_new[B_ACT] = 1'b0;
      case (kind)
        RS_OK: begin
          ctrl_new[LEN_W-1:0] = eff_len - LEN_W'(1);
          ctrl_new[B_ACT]     = 1'b0;
          if (is_in && ctrl[B_SPD] && eff_len < max_len) cause[1] = 1'b1;
          else verdict = VD_ADV;
        end
        RS_NAK: begin
          ctrl_new[B_NAK] = 1'b1;
          tmo_path        = is_setup;
        end
        RS_STALL: begin
          ctrl_new[B_STALL] = 1'b1;
          ctrl_new[B_ACT]   = 1'b0;
        end
        RS_BABBLE: begin
          ctrl_new[B_BABBLE] = 1'b1;
          ctrl_new[B_STALL]  = 1'b1;
          ctrl_new[B_ACT]    = 1'b0;
          verdict            = VD_ABORT;
        end
        default: tmo_path = 1'b1;
      endcase
      if (tmo_path) begin
        ctrl_new[B_TMO] = 1'b1;
        if (err_cnt != 2'd0) begin
          ctrl_new[B_ERR_LO+1:B_ERR_LO] = err_cnt - 2'd1;
          if (err_cnt == 2'd1) begin
            ctrl_new[B_ACT] = 1'b0;
            usb_err         = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/td_out_reg.sv
module td_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic         vld,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      q   <= '0;
    end else begin
      vld <= en;
      if (en) q <= d;
    end
  end
endmodule

// File: rtl/td_status_unit.sv
module td_status_unit
  import td_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int RLEN_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       ctrl_in,
  input  logic [31:0]       token_in,
  input  logic [2:0]        res_kind,
  input  logic [RLEN_W-1:0] res_len,
  output logic              out_valid,
  output logic [31:0]       ctrl_out,
  output logic [1:0]        verdict,
  output logic [1:0]        cause,
  output logic              usb_err,
  output logic              proc_err,
  output logic              ctrl_changed,
  output logic [7:0]        pid,
  output logic [6:0]        dev_addr,
  output logic [3:0]        endpoint,
  output logic [LEN_W-1:0]  max_len
);
  localparam int PAY_W = WORD_W + 2 + 2 + 3 + 8 + 7 + 4 + LEN_W;

  logic [7:0]        d_pid;
  logic [6:0]        d_addr;
  logic [3:0]        d_ep;
  logic [LEN_W-1:0]  d_max;
  logic [WORD_W-1:0] d_ctrl;
  verdict_e          d_vd;
  logic [1:0]        d_cause;
  logic              d_ue, d_pe, d_chg;
  logic [PAY_W-1:0]  pay_d, pay_q;

  td_tok_decode #(.LEN_W(LEN_W)) u_dec (
    .token(token_in), .pid(d_pid), .dev_addr(d_addr),
    .endpoint(d_ep), .max_len(d_max)
  );

  td_eval #(.LEN_W(LEN_W), .RLEN_W(RLEN_W)) u_eval (
    .ctrl(ctrl_in), .pid(d_pid), .max_len(d_max), .res_kind(res_kind),
    .res_len(res_len), .ctrl_new(d_ctrl), .verdict(d_vd), .cause(d_cause),
    .usb_err(d_ue), .proc_err(d_pe)
  );

  assign d_chg = (d_ctrl != ctrl_in);
  assign pay_d = {d_ctrl, d_vd, d_cause, d_ue, d_pe, d_chg,
                  d_pid, d_addr, d_ep, d_max};

  td_out_reg #(.W(PAY_W)) u_reg (
    .clk(clk), .rst(rst), .en(in_valid), .d(pay_d),
    .vld(out_valid), .q(pay_q)
  );

  assign {ctrl_out, verdict, cause, usb_err, proc_err, ctrl_changed,
          pid, dev_addr, endpoint, max_len} = pay_q;
endmodule

// File: rtl/td_status_checker.sv
module td_status_checker
  import td_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] ctrl_in,
  input logic        out_valid,
  input logic [31:0] ctrl_out,
  input logic [1:0]  verdict,
  input logic [1:0]  cause,
  input logic        usb_err,
  input logic        proc_err,
  input logic        ctrl_changed
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_ioc_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctrl_in[B_IOC]) |=> cause[0]);
  p_inactive_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ctrl_in[B_ACT]) |=>
      (ctrl_out == $past(ctrl_in) && verdict == VD_HOLD && !ctrl_changed));
  p_perr_abort_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && proc_err) |-> (verdict == VD_ABORT && !usb_err));
  p_advance_inactive_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && verdict == VD_ADV) |-> !ctrl_out[B_ACT]);
  p_short_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cause[1]) |-> verdict == VD_HOLD);
  p_babble_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && verdict == VD_ABORT && !proc_err) |->
      (ctrl_out[B_BABBLE] && ctrl_out[B_STALL] && !ctrl_out[B_ACT]));
  p_usberr_state_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && usb_err) |->
      (!ctrl_out[B_ACT] && ctrl_out[B_TMO] && ctrl_out[B_ERR_LO+1:B_ERR_LO] == 2'd0));
  p_changed_flag_r13: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (ctrl_changed == (ctrl_out != $past(ctrl_in))));
endmodule

bind td_status_unit td_status_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl_in(ctrl_in),
  .out_valid(out_valid), .ctrl_out(ctrl_out), .verdict(verdict),
  .cause(cause), .usb_err(usb_err), .proc_err(proc_err),
  .ctrl_changed(ctrl_changed)
);

// File: tb/sim_td_status_unit.sv
module sim_td_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] ctrl_in = '0, token_in = '0;
  logic [2:0]  res_kind = '0;
  logic [11:0] res_len = '0;
  logic        out_valid, usb_err, proc_err, ctrl_changed;
  logic [31:0] ctrl_out;
  logic [1:0]  verdict, cause;
  logic [7:0]  pid;
  logic [6:0]  dev_addr;
  logic [3:0]  endpoint;
  logic [10:0] max_len;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  td_status_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl_in(ctrl_in),
    .token_in(token_in), .res_kind(res_kind), .res_len(res_len),
    .out_valid(out_valid), .ctrl_out(ctrl_out), .verdict(verdict),
    .cause(cause), .usb_err(usb_err), .proc_err(proc_err),
    .ctrl_changed(ctrl_changed), .pid(pid), .dev_addr(dev_addr),
    .endpoint(endpoint), .max_len(max_len)
  );

  typedef struct packed {
    logic [31:0] c;
    logic [1:0]  v;
    logic [1:0]  cs;
    logic        ue;
    logic        pe;
  } exp_t;

  function automatic bit pid_valid(input logic [7:0] p);
    return p == 8'hE1 || p == 8'h69 || p == 8'h2D;
  endfunction

  function automatic int max_of(input logic [31:0] t);
    return (int'(t[31:21]) + 1) % 2048;
  endfunction

  function automatic exp_t model(input logic [31:0] c, input logic [31:0] t,
                                 input logic [2:0] k, input logic [11:0] rl);
    exp_t e;
    int mx, n;
    bit tmo;
    logic [7:0] p;
    logic [1:0] ec;
    logic [2:0] kk;
    p = t[7:0]; mx = max_of(t); kk = k; tmo = 0;
    e.c = c; e.v = 2'b01; e.cs = {1'b0, c[24]}; e.ue = 0; e.pe = 0;
    if (!c[23]) return e;
    if (!pid_valid(p)) begin e.pe = 1; e.v = 2'b10; return e; end
    if (c[25]) e.c[23] = 0;
    n = (p == 8'h69) ? int'(rl) : mx;
    if (p == 8'h69 && kk == 3'd0 && n > mx) kk = 3'd4;
    case (kk)
      3'd0: begin
        e.c[10:0] = 11'(n + 2047);
        e.c[23] = 0;
        if (p == 8'h69 && c[29] && n < mx) e.cs[1] = 1;
        else e.v = 2'b00;
      end
      3'd2: begin e.c[19] = 1; tmo = (p == 8'h2D); end
      3'd3: begin e.c[22] = 1; e.c[23] = 0; end
      3'd4: begin e.c[20] = 1; e.c[22] = 1; e.c[23] = 0; e.v = 2'b10; end
      default: tmo = 1;
    endcase
    if (tmo) begin
      e.c[18] = 1;
      ec = c[28:27];
      if (ec != 0) begin
        e.c[28:27] = ec - 2'd1;
        if (ec == 2'd1) begin e.c[23] = 0; e.ue = 1; end
      end
    end
    return e;
  endfunction

  function automatic string tag_of(input logic [31:0] c, input logic [31:0] t,
                                   input logic [2:0] k, input logic [11:0] rl);
    if (!c[23]) return "R4";
    if (!pid_valid(t[7:0])) return "R5";
    if (k == 3'd0 && t[7:0] == 8'h69 && int'(rl) > max_of(t)) return "R8";
    case (k)
      3'd0: return (t[7:0] == 8'h69 && c[29]) ? "R7" : "R6";
      3'd2: return "R10";
      3'd3: return "R11";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] c, input logic [31:0] t,
                         input logic [2:0] k, input logic [11:0] rl,
                         input string req);
    exp_t e;
    e = model(c, t, k, rl);
    @(negedge clk);
    ctrl_in = c; token_in = t; res_kind = k; res_len = rl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R2", "out_valid", 32'(out_valid), 32'd1);
    check(ctrl_out == e.c, req, "ctrl_out", ctrl_out, e.c);
    check(verdict == e.v, req, "verdict", 32'(verdict), 32'(e.v));
    check(cause == e.cs, (e.cs[0] ? "R3" : req), "cause", 32'(cause), 32'(e.cs));
    check(usb_err == e.ue, req, "usb_err", 32'(usb_err), 32'(e.ue));
    check(proc_err == e.pe, req, "proc_err", 32'(proc_err), 32'(e.pe));
    check(ctrl_changed == (e.c != c), "R13", "ctrl_changed",
          32'(ctrl_changed), 32'(e.c != c));
    check({pid, dev_addr, endpoint} == {t[7:0], t[14:8], t[18:15]}, "R2",
          "decode", 32'({pid, dev_addr, endpoint}), 32'({t[7:0], t[14:8], t[18:15]}));
    check(int'(max_len) == max_of(t), "R2", "max_len", 32'(max_len), 32'(max_of(t)));
  endtask

  function automatic logic [31:0] tok(input logic [7:0] p, input int mxm1);
    return {11'(mxm1), 2'b00, 4'd3, 7'd5, p};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(out_valid == 0 && ctrl_out == 0 && verdict == 0 && cause == 0,
          "R1", "reset outputs", ctrl_out, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && max_len == 0, "R1", "after reset", 32'(out_valid), 32'd0);

    // directed corners
    run_vec(32'h0100_0000, tok(8'h69, 7), 3'd0, 12'd8, "R4");             // inactive with IOC
    run_vec(32'h0180_0000, tok(8'h55, 7), 3'd0, 12'd8, "R5");             // bad pid, IOC
    run_vec(32'h0080_0000, tok(8'hE1, 63), 3'd0, 12'd0, "R6");            // OUT success
    run_vec(32'h0080_0000, tok(8'h69, 63), 3'd0, 12'd64, "R6");           // IN full
    run_vec(32'h2080_0000, tok(8'h69, 63), 3'd0, 12'd10, "R7");           // IN short, SPD
    run_vec(32'h0080_0000, tok(8'h69, 63), 3'd0, 12'd10, "R6");           // IN short, no SPD
    run_vec(32'h0080_0123, tok(8'h69, 63), 3'd0, 12'd65, "R8");           // clipped
    run_vec(32'h0080_0000, tok(8'h69, 2047), 3'd0, 12'd0, "R6");          // max wraps to 0
    run_vec(32'h0080_0000, tok(8'h69, 2047), 3'd0, 12'd1, "R8");
    run_vec(32'h0080_0000, tok(8'hE1, 2047), 3'd0, 12'd0, "R6");
    run_vec(32'h1880_0000, tok(8'hE1, 7), 3'd1, 12'd0, "R9");             // err 3 -> 2
    run_vec(32'h0880_0000, tok(8'hE1, 7), 3'd6, 12'd0, "R9");             // err 1 -> 0
    run_vec(32'h0080_0000, tok(8'hE1, 7), 3'd1, 12'd0, "R9");             // err 0 stays
    run_vec(32'h0880_0000, tok(8'h69, 7), 3'd2, 12'd0, "R10");            // NAK IN
    run_vec(32'h0880_0000, tok(8'h2D, 7), 3'd2, 12'd0, "R10");            // NAK SETUP expires
    run_vec(32'h0080_0000, tok(8'h69, 7), 3'd3, 12'd0, "R11");
    run_vec(32'h0080_0000, tok(8'hE1, 7), 3'd4, 12'd0, "R8");
    run_vec(32'h0280_0000, tok(8'h69, 7), 3'd2, 12'd0, "R12");            // iso NAK
    run_vec(32'h0280_0000, tok(8'hE1, 7), 3'd1, 12'd0, "R12");
    run_vec(32'h1A80_0000, tok(8'h2D, 7), 3'd1, 12'd0, "R12");
    @(negedge clk);
    check(out_valid == 0, "R2", "idle out_valid", 32'(out_valid), 32'd0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] c, t;
      logic [2:0]  k;
      logic [11:0] rl;
      int sel, mx;
      c = $urandom;
      if ($urandom % 5 != 0) c[23] = 1'b1;
      t = $urandom;
      if ($urandom % 3 == 0) t[31:21] = 11'($urandom % 16);
      sel = int'($urandom % 7);
      case (sel)
        0, 1: t[7:0] = 8'h69;
        2, 3: t[7:0] = 8'hE1;
        4, 5: t[7:0] = 8'h2D;
        default: t[7:0] = 8'($urandom);
      endcase
      k = ($urandom % 2 == 0) ? 3'd0 : 3'($urandom);
      mx = max_of(t);
      case ($urandom % 4)
        0: rl = 12'(mx);
        1: rl = 12'(mx + 1);
        2: rl = (mx > 0) ? 12'(mx - 1) : 12'd0;
        default: rl = 12'($urandom);
      endcase
      run_vec(c, t, k, rl, tag_of(c, t, k, rl));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule